// File: doc/BRIEF.md
# Banked Data Memory with Status Register

This block is the data-memory side of a small 8-bit microcontroller core. It keeps two register banks. The bank-select bit held in the status register picks the bank. Every access is steered into one of three kinds of location: a special-function slot, general-purpose RAM, or a hole that reads as zero. The instruction decoder presents a 7-bit in-bank address with the data to write, and it reads the addressed location combinationally. When the in-bank address names the indirect-data slot, the 8-bit file-select pointer becomes the whole address. That pointer lives in this block.

The status register has its own write rules. The ALU reports which of its three arithmetic flags (zero, digit carry, carry) the current instruction produces, together with their values. If the same instruction also writes the status register as data, the data is discarded on all three flag bits. The timeout and power-down bits never accept a write. In the upper bank, the top sixteen addresses alias the last sixteen bytes of general-purpose RAM in the lower bank, so a few variables can be reached without switching banks.

Top module: `dmem_status_bank`

## Requirements
- R1: After reset, STATUS reads 0x18 (timeout and power-down set, all other bits clear), the file-select pointer reads 0x00, and every general-purpose byte reads 0x00.
- R2: A direct access uses the 8-bit address {STATUS bit 5, addr_i}. Bank 0 is selected when bit 5 is 0 and bank 1 when it is 1.
- R3: Addresses 0x40 to 0x7F are general-purpose RAM: a written byte reads back unchanged on the next cycle.
- R4: Addresses 0xF0 to 0xFF reach the same storage as 0x70 to 0x7F.
- R5: Every other location reads 0x00 and ignores writes. This covers 0x20–0x3F, 0xA0–0xEF, and every special-function slot (in-bank offsets 0x00–0x1F) other than STATUS and the pointer.
- R6: STATUS sits at in-bank offset 0x03 and the file-select pointer at offset 0x04. Each is the same register in both banks.
- R7: An access to in-bank offset 0x00 uses the pointer as the full 8-bit address. If the pointer itself addresses offset 0x00 of either bank, the access reads 0x00 and writes nothing.
- R8: A data write to STATUS with no flag update loads bits 7:5 and 2:0 from the data. Bits 4:3 (timeout, power-down) never change by any write.
- R9: Flag update port: flag_we_i bit 2 = Z (STATUS bit 2), bit 1 = DC (bit 1), bit 0 = C (bit 0). Each enabled flag takes its value from flag_val_i, whether or not STATUS is also written that cycle.
- R10: When STATUS is written while any flag is updated, the data value is discarded for all three flag bits. Flags that are not enabled hold their value, so writing 0x00 with only Z updated to 1 gives 000u_u1uu.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | In-bank address of the access |
| wr_en_i | input | 1 | Write wr_data_i to the addressed location at the clock edge |
| wr_data_i | input | 8 | Write data |
| flag_we_i | input | 3 | Per-flag update enable from the ALU (Z, DC, C) |
| flag_val_i | input | 3 | Flag values from the ALU (Z, DC, C) |
| rd_data_o | output | 8 | Combinational read of the addressed location |
| status_o | output | 8 | Current STATUS contents |

## Verification
Writes and read-backs are tried with the bank bit at both values. This separates correct bank concatenation from a decoder that ignores the bank bit: the same in-bank address lands in RAM in bank 0 and in a hole in bank 1. Indirect accesses use pointer values that land in RAM, in the upper-bank alias, on STATUS and on the indirect slot itself, which shows that the pointer replaces the whole address. STATUS is driven with data writes alone, with flag updates alone, and with both together under partial flag masks. Only that last pattern tells the flag-shield rule apart from a plain per-bit merge.

// File: rtl/dm_pkg.sv
package dm_pkg;

   typedef enum logic [1:0] {
      RG_NONE   = 2'd0,
      RG_GPR    = 2'd1,
      RG_STATUS = 2'd2,
      RG_PTR    = 2'd3
   } dm_region_e;

   localparam int FLAG_N = 3;

endpackage

// File: rtl/dm_addr_decode.sv
module dm_addr_decode
   import dm_pkg::*;
#(
   parameter int DIR_AW      = 7,
   parameter int SFR_SPAN    = 32,
   parameter int INDF_OFS    = 0,
   parameter int STATUS_OFS  = 3,
   parameter int PTR_OFS     = 4,
   parameter int GPR_BASE    = 'h40,
   parameter int GPR_DEPTH   = 64,
   parameter bit MIRROR_EN   = 1'b1,
   parameter int MIRROR_BASE = 'hF0,
   parameter int MIRROR_LEN  = 16,
   localparam int FULL_AW    = DIR_AW + 1,
   localparam int GPR_IW     = $clog2(GPR_DEPTH)
)(
   input  logic [DIR_AW-1:0]  dir_addr_i,
   input  logic               bank_i,
   input  logic [FULL_AW-1:0] ptr_i,
   output logic [FULL_AW-1:0] eff_addr_o,
   output dm_region_e         region_o,
   output logic [GPR_IW-1:0]  gpr_idx_o
);

   localparam int GPR_END    = GPR_BASE + GPR_DEPTH;
   localparam int MIRROR_TGT = GPR_END - MIRROR_LEN;

   logic [FULL_AW-1:0] page_addr;
   logic               via_ptr;
   int                 ea;
   int                 offs;
   logic               mirror_hit;
   logic [GPR_IW-1:0]  mirror_idx;

   assign page_addr  = {bank_i, dir_addr_i};
   assign via_ptr    = (dir_addr_i == DIR_AW'(INDF_OFS));
   assign eff_addr_o = via_ptr ? ptr_i : page_addr;
   assign ea         = int'(eff_addr_o);
   assign offs       = int'(eff_addr_o[DIR_AW-1:0]);

   generate
      if (MIRROR_EN) begin : g_mirror
         assign mirror_hit = (ea >= MIRROR_BASE) && (ea < MIRROR_BASE + MIRROR_LEN);
         assign mirror_idx = GPR_IW'(ea - MIRROR_BASE + (MIRROR_TGT - GPR_BASE));
      end else begin : g_no_mirror
         assign mirror_hit = 1'b0;
         assign mirror_idx = '0;
      end
   endgenerate

   always_comb begin
      region_o  = RG_NONE;
      gpr_idx_o = '0;
      if (offs < SFR_SPAN) begin
         if (offs == STATUS_OFS)   region_o = RG_STATUS;
         else if (offs == PTR_OFS) region_o = RG_PTR;
      end else if ((ea >= GPR_BASE) && (ea < GPR_END)) begin
         region_o  = RG_GPR;
         gpr_idx_o = GPR_IW'(ea - GPR_BASE);
      end else if (mirror_hit) begin
         region_o  = RG_GPR;
         gpr_idx_o = mirror_idx;
      end
   end

endmodule

// File: rtl/dm_gpr_file.sv
module dm_gpr_file #(
   parameter int DW        = 8,
   parameter int DEPTH     = 64,
   localparam int IW       = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [IW-1:0] idx_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);

   logic [DEPTH-1:0][DW-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mem_q <= '0;
      else if (we_i) mem_q[idx_i] <= wdata_i;
   end

   assign rdata_o = mem_q[idx_i];

   AST_RAM_QUIET_UNLESS_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(mem_q)); // R5
   AST_RAM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mem_q[$past(idx_i)] == $past(wdata_i))); // R3

endmodule

// File: rtl/dm_status_reg.sv
module dm_status_reg
   import dm_pkg::*;
#(
   parameter int          DW       = 8,
   parameter logic [DW-1:0] RST_VAL  = 8'h18,
   parameter logic [DW-1:0] DATA_MASK = 8'hE0,
   parameter logic [DW-1:0] LOCK_MASK = 8'h18
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DW-1:0]     wr_data_i,
   input  logic [FLAG_N-1:0] flag_we_i,
   input  logic [FLAG_N-1:0] flag_val_i,
   output logic [DW-1:0]     q_o
);

   logic [DW-1:0] nxt;
   logic          flags_busy;

   assign flags_busy = |flag_we_i;

   always_comb begin
      nxt = q_o;
      for (int b = 0; b < DW; b++) begin
         if (b < FLAG_N) begin
            if (flag_we_i[b])                  nxt[b] = flag_val_i[b];
            else if (wr_en_i && !flags_busy)   nxt[b] = wr_data_i[b];
         end else if (DATA_MASK[b] && wr_en_i) begin
            nxt[b] = wr_data_i[b];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= nxt;
   end

   AST_LOCKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & LOCK_MASK) == (RST_VAL & LOCK_MASK))); // R8
   AST_UPPER_BITS_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> ((q_o & DATA_MASK) == ($past(wr_data_i) & DATA_MASK))); // R8
   AST_FLAG_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
      flags_busy |=> ((q_o[FLAG_N-1:0] & $past(flag_we_i)) ==
                      ($past(flag_val_i) & $past(flag_we_i)))); // R9
   AST_FLAG_SHIELD: assert property (@(posedge clk) disable iff (!rst_n)
      flags_busy |=> ((q_o[FLAG_N-1:0] & ~$past(flag_we_i)) ==
                      ($past(q_o[FLAG_N-1:0]) & ~$past(flag_we_i)))); // R10

endmodule

// File: rtl/dmem_status_bank.sv
module dmem_status_bank
   import dm_pkg::*;
#(
   parameter int DW          = 8,
   parameter int DIR_AW      = 7,
   parameter int SFR_SPAN    = 32,
   parameter int INDF_OFS    = 0,
   parameter int STATUS_OFS  = 3,
   parameter int PTR_OFS     = 4,
   parameter int BANK_BIT    = 5,
   parameter int GPR_BASE    = 'h40,
   parameter int GPR_DEPTH   = 64,
   parameter bit MIRROR_EN   = 1'b1,
   parameter int MIRROR_BASE = 'hF0,
   parameter int MIRROR_LEN  = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIR_AW-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DW-1:0]     wr_data_i,
   input  logic [2:0]        flag_we_i,
   input  logic [2:0]        flag_val_i,
   output logic [DW-1:0]     rd_data_o,
   output logic [DW-1:0]     status_o
);

   localparam int FULL_AW   = DIR_AW + 1;
   localparam int BANK_SIZE = 1 << DIR_AW;
   localparam int GPR_IW    = $clog2(GPR_DEPTH);

   generate
      if (DW != FULL_AW) begin : g_bad_width
         $error("pointer must span exactly two banks");
      end
      if (GPR_BASE < SFR_SPAN || GPR_BASE + GPR_DEPTH > BANK_SIZE) begin : g_bad_gpr
         $error("general-purpose window must sit in bank 0 above the special slots");
      end
      if (MIRROR_EN && (MIRROR_LEN > GPR_DEPTH || MIRROR_BASE < BANK_SIZE + SFR_SPAN
                        || MIRROR_BASE + MIRROR_LEN > 2 * BANK_SIZE)) begin : g_bad_mirror
         $error("alias window must lie in bank 1 and fit the RAM");
      end
      if (BANK_BIT < FLAG_N || BANK_BIT >= DW) begin : g_bad_bank
         $error("bank bit must lie above the flag bits");
      end
      if (INDF_OFS == STATUS_OFS || INDF_OFS == PTR_OFS || STATUS_OFS == PTR_OFS
          || INDF_OFS >= SFR_SPAN || STATUS_OFS >= SFR_SPAN || PTR_OFS >= SFR_SPAN) begin : g_bad_sfr
         $error("special slots must be distinct and inside the special span");
      end
   endgenerate

   logic [FULL_AW-1:0] ptr_q;
   logic [FULL_AW-1:0] eff_addr;
   dm_region_e         region;
   logic [GPR_IW-1:0]  gpr_idx;
   logic [DW-1:0]      gpr_rd;
   logic [DW-1:0]      status_q;
   logic               gpr_we;
   logic               status_we;
   logic               ptr_we;

   dm_addr_decode #(
      .DIR_AW(DIR_AW), .SFR_SPAN(SFR_SPAN), .INDF_OFS(INDF_OFS),
      .STATUS_OFS(STATUS_OFS), .PTR_OFS(PTR_OFS), .GPR_BASE(GPR_BASE),
      .GPR_DEPTH(GPR_DEPTH), .MIRROR_EN(MIRROR_EN), .MIRROR_BASE(MIRROR_BASE),
      .MIRROR_LEN(MIRROR_LEN)
   ) u_decode (
      .dir_addr_i (addr_i),
      .bank_i     (status_q[BANK_BIT]),
      .ptr_i      (ptr_q),
      .eff_addr_o (eff_addr),
      .region_o   (region),
      .gpr_idx_o  (gpr_idx)
   );

   assign gpr_we    = wr_en_i && (region == RG_GPR);
   assign status_we = wr_en_i && (region == RG_STATUS);
   assign ptr_we    = wr_en_i && (region == RG_PTR);

   dm_gpr_file #(.DW(DW), .DEPTH(GPR_DEPTH)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (gpr_we),
      .idx_i   (gpr_idx),
      .wdata_i (wr_data_i),
      .rdata_o (gpr_rd)
   );

   dm_status_reg #(.DW(DW)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (status_we),
      .wr_data_i  (wr_data_i),
      .flag_we_i  (flag_we_i),
      .flag_val_i (flag_val_i),
      .q_o        (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= '0;
      else if (ptr_we) ptr_q <= wr_data_i;
   end

   always_comb begin
      unique case (region)
         RG_GPR:    rd_data_o = gpr_rd;
         RG_STATUS: rd_data_o = status_q;
         RG_PTR:    rd_data_o = ptr_q;
         default:   rd_data_o = '0;
      endcase
   end

   assign status_o = status_q;

   AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_NONE) |-> (rd_data_o == '0)); // R5
   AST_DIRECT_USES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i != DIR_AW'(INDF_OFS)) |-> (eff_addr[FULL_AW-1] == status_q[BANK_BIT])); // R2
   AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_we |=> $stable(ptr_q)); // R6

endmodule

// File: tb/dmem_status_bank_tb.sv
module dmem_status_bank_tb;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [6:0] wa;
      logic       we;
      logic [7:0] wd;
      logic [2:0] fwe;
      logic [2:0] fv;
      logic [6:0] ra;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NVEC = 27;
   localparam vec_t VEC [NVEC] = '{
      '{7'h45, 1'b1, 8'hA5, 3'b000, 3'b000, 7'h45, 8'hA5, 4'd3},  // R3 bank0 RAM
      '{7'h20, 1'b1, 8'h11, 3'b000, 3'b000, 7'h20, 8'h00, 4'd5},  // R5 hole 0x20
      '{7'h7F, 1'b1, 8'h3C, 3'b000, 3'b000, 7'h7F, 8'h3C, 4'd3},  // R3 top of RAM
      '{7'h03, 1'b1, 8'h20, 3'b000, 3'b000, 7'h03, 8'h38, 4'd8},  // R8 select bank1
      '{7'h7F, 1'b1, 8'h5A, 3'b000, 3'b000, 7'h7F, 8'h5A, 4'd4},  // R4 write 0xFF
      '{7'h45, 1'b1, 8'h77, 3'b000, 3'b000, 7'h45, 8'h00, 4'd5},  // R5 hole 0xC5
      '{7'h10, 1'b1, 8'h44, 3'b000, 3'b000, 7'h10, 8'h00, 4'd5},  // R5 unused special 0x90
      '{7'h04, 1'b1, 8'h45, 3'b000, 3'b000, 7'h04, 8'h45, 4'd6},  // R6 pointer via 0x84
      '{7'h00, 1'b1, 8'h99, 3'b000, 3'b000, 7'h00, 8'h99, 4'd7},  // R7 indirect to 0x45
      '{7'h03, 1'b1, 8'h07, 3'b000, 3'b000, 7'h03, 8'h1F, 4'd8},  // R8 back to bank0
      '{7'h00, 1'b0, 8'h00, 3'b000, 3'b000, 7'h45, 8'h99, 4'd2},  // R2 bank0 sees 0x45
      '{7'h00, 1'b0, 8'h00, 3'b000, 3'b000, 7'h7F, 8'h5A, 4'd4},  // R4 alias readback
      '{7'h00, 1'b0, 8'h00, 3'b000, 3'b000, 7'h70, 8'h00, 4'd3},  // R3 untouched byte
      '{7'h03, 1'b1, 8'hE0, 3'b011, 3'b010, 7'h03, 8'hFE, 4'd10}, // R10 Z shielded
      '{7'h03, 1'b1, 8'h00, 3'b100, 3'b100, 7'h03, 8'h1E, 4'd10}, // R10 clear pattern
      '{7'h00, 1'b0, 8'h00, 3'b001, 3'b001, 7'h03, 8'h1F, 4'd9},  // R9 flag only
      '{7'h03, 1'b1, 8'h00, 3'b000, 3'b000, 7'h03, 8'h18, 4'd8},  // R8 locked bits stay
      '{7'h04, 1'b1, 8'hF5, 3'b000, 3'b000, 7'h04, 8'hF5, 4'd6},  // R6 pointer via 0x04
      '{7'h00, 1'b1, 8'h66, 3'b000, 3'b000, 7'h75, 8'h66, 4'd7},  // R7 indirect into alias
      '{7'h04, 1'b1, 8'h00, 3'b000, 3'b000, 7'h04, 8'h00, 4'd6},  // R6
      '{7'h00, 1'b1, 8'h55, 3'b000, 3'b000, 7'h00, 8'h00, 4'd7},  // R7 self-pointing
      '{7'h04, 1'b1, 8'h03, 3'b000, 3'b000, 7'h00, 8'h18, 4'd7},  // R7 indirect STATUS
      '{7'h00, 1'b1, 8'h3B, 3'b000, 3'b000, 7'h03, 8'h3B, 4'd7},  // R7 indirect write
      '{7'h03, 1'b1, 8'h00, 3'b000, 3'b000, 7'h03, 8'h18, 4'd8},  // R8 restore
      '{7'h45, 1'b1, 8'h12, 3'b111, 3'b101, 7'h03, 8'h1D, 4'd9},  // R9 flags during RAM write
      '{7'h00, 1'b0, 8'h00, 3'b000, 3'b000, 7'h45, 8'h12, 4'd3},  // R3
      '{7'h00, 1'b0, 8'h00, 3'b000, 3'b000, 7'h7F, 8'h5A, 4'd4}   // R4 alias still intact
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] addr_i = '0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic [2:0] flag_we_i = '0;
   logic [2:0] flag_val_i = '0;
   logic [7:0] rd_data_o;
   logic [7:0] status_o;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmem_status_bank u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (addr_i),
      .wr_en_i    (wr_en_i),
      .wr_data_i  (wr_data_i),
      .flag_we_i  (flag_we_i),
      .flag_val_i (flag_val_i),
      .rd_data_o  (rd_data_o),
      .status_o   (status_o)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic read_at(input logic [6:0] a, input logic [7:0] exp, input int req, input string what);
      @(negedge clk);
      addr_i = a; wr_en_i = 1'b0; flag_we_i = '0;
      #1 check(rd_data_o, exp, req, what);
   endtask

   task automatic run_vec(input vec_t v);
      @(negedge clk);
      addr_i = v.wa; wr_en_i = v.we; wr_data_i = v.wd;
      flag_we_i = v.fwe; flag_val_i = v.fv;
      @(negedge clk);
      addr_i = v.ra; wr_en_i = 1'b0; flag_we_i = '0;
      #1 check(rd_data_o, v.exp, int'(v.req), "vector");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      read_at(7'h03, 8'h18, 1, "STATUS after reset");
      read_at(7'h04, 8'h00, 1, "pointer after reset");
      read_at(7'h45, 8'h00, 1, "RAM after reset");
      read_at(7'h7F, 8'h00, 1, "RAM top after reset");
      #1 check(status_o, 8'h18, 1, "status port after reset");

      for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

      // R1 reset mid-run clears RAM, pointer and STATUS
      @(negedge clk);
      addr_i = 7'h03; wr_en_i = 1'b1; wr_data_i = 8'hE7; flag_we_i = '0;
      @(negedge clk);
      wr_en_i = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      read_at(7'h03, 8'h18, 1, "STATUS after second reset");
      read_at(7'h45, 8'h00, 1, "RAM after second reset");
      read_at(7'h75, 8'h00, 1, "aliased RAM after second reset");
      read_at(7'h04, 8'h00, 1, "pointer after second reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule